// File: doc/BRIEF.md
# Two-Level Active Warp Scheduler

This block keeps the issue priority order for a fixed pool of warps. A bounded active set, of at most `MAX_ACTIVE` warps, is offered to the issue stage as an ordered list. Slot 0 of the list has the highest priority. All other warps wait in a first-in first-out pending queue. The issue checks themselves are not part of the block. The issue stage reads the list and reports which warp, if any, it issued in that cycle.

On every clock edge the block computes the next order in three steps.

1. If a warp issued, the active list is rotated so that the issuing warp becomes the lowest-priority entry.
2. Each active warp is examined. A warp is demoted if its waiting flag is set. It is also demoted if any non-zero source register of its next instruction is marked busy on a long-latency operation in the per-warp scoreboard view. Demoted warps go to the tail of the pending queue.
3. Warps are taken from the head of the pending queue and appended to the active tail until the active set is full again.

Because the pool size is fixed and is at least `MAX_ACTIVE`, the active set always stays full. In each cycle the number of warps promoted equals the number demoted.

Top module: `warp_twolevel_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, the active list holds warps 0 to `MAX_ACTIVE-1` in index order, with warp 0 in slot 0. Warp `w` occupies `act_list[w*WID_W +: WID_W]`, and slot 0 has the highest priority. The pending queue holds the remaining warps in ascending order, with the lowest index at its head.
- R2: An active warp whose `wait_flag` bit is set at a clock edge is absent from the active list after that edge. This holds as long as the pending queue holds at least as many warps as were demoted in that cycle.
- R3: An active warp is demoted if any of its `NUM_SRC` source fields is non-zero and the scoreboard bit for that warp and register is set. Source field `s` of warp `w` is `src_reg[(w*NUM_SRC+s)*REG_W +: REG_W]`. The scoreboard bit is `long_busy[w*2**REG_W + reg]`.
- R4: A source field equal to zero never causes a demotion, even when the scoreboard bit for register 0 of that warp is set.
- R5: Several warps demoted in the same cycle join the pending tail in their active-list order. They follow every warp that was already pending.
- R6: Vacated active slots are refilled from the pending head in queue order. The promoted warps are appended after the surviving active warps, which keep their relative order.
- R7: The active list always holds exactly `MAX_ACTIVE` distinct warps.
- R8: When `issue_vld` is high and `issue_wid` is in the active list, the list is rotated. The warps after the issuing warp move to the front, the warps before it follow, and the issuing warp takes the last slot.
- R9: The rotation is applied before demotion in the same cycle. An issuing warp that is also stalled is demoted, and the survivors keep their rotated order.
- R10: With `issue_vld` low and no active warp stalled, the active list does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_flag | input | NUM_WARPS | Per-warp waiting flag |
| src_reg | input | NUM_WARPS*NUM_SRC*REG_W | Source register numbers of each warp's next instruction |
| long_busy | input | NUM_WARPS*2**REG_W | Per-warp, per-register long-latency pending bits |
| issue_vld | input | 1 | The issue stage issued a warp this cycle |
| issue_wid | input | WID_W | Index of the warp that issued |
| act_list | output | MAX_ACTIVE*WID_W | Ordered active list, slot 0 first |

## Verification
The assertions assume that `issue_wid` names a warp that is in the active list whenever `issue_vld` is high. The bench only ever picks the issuing warp from its own model of the current active list. The check that a flagged warp leaves the active list assumes the pending queue is at least as large as the active set. The default configuration of eight warps with four active satisfies this. The rotation and hold checks are only claimed in cycles where no waiting flag or busy bit is present. The directed phases of the stimulus clear those inputs whenever they exercise rotation alone.

// File: rtl/wts_pkg.sv
package wts_pkg;

    localparam int DEF_WARPS  = 8;
    localparam int DEF_ACTIVE = 4;
    localparam int DEF_SRCS   = 4;
    localparam int DEF_REG_W  = 4;

    // Wrap an index that is known to be below 2*m back into [0, m).
    function automatic int wrap_slot(input int v, input int m);
        return (v >= m) ? v - m : v;
    endfunction

endpackage

// File: rtl/wts_stall_detect.sv
module wts_stall_detect #(
    parameter int NUM_WARPS = wts_pkg::DEF_WARPS,
    parameter int NUM_SRC   = wts_pkg::DEF_SRCS,
    parameter int REG_W     = wts_pkg::DEF_REG_W
) (
    input  logic [NUM_WARPS-1:0]               wait_flag,
    input  logic [NUM_WARPS*NUM_SRC*REG_W-1:0] src_reg,
    input  logic [NUM_WARPS*(2**REG_W)-1:0]    long_busy,
    output logic [NUM_WARPS-1:0]               stall_o
);
    localparam int NUM_REGS = 2 ** REG_W;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic st;
        always_comb begin
            logic [REG_W-1:0] r;
            st = wait_flag[w];
            for (int s = 0; s < NUM_SRC; s++) begin
                r = src_reg[(w*NUM_SRC + s)*REG_W +: REG_W];
                if (r != '0 && long_busy[w*NUM_REGS + int'(r)]) st = 1'b1;
            end
        end
        assign stall_o[w] = st;
    end
endmodule

// File: rtl/wts_rotate.sv
module wts_rotate #(
    parameter int NUM_WARPS  = wts_pkg::DEF_WARPS,
    parameter int MAX_ACTIVE = wts_pkg::DEF_ACTIVE,
    parameter int WID_W      = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS*WID_W-1:0] ord_i,
    input  logic                       issue_vld,
    input  logic [WID_W-1:0]           issue_wid,
    output logic [NUM_WARPS*WID_W-1:0] rot_o
);
    always_comb begin
        logic hit;
        int   k;
        int   idx;
        hit   = 1'b0;
        k     = 0;
        idx   = 0;
        rot_o = ord_i;
        for (int i = 0; i < MAX_ACTIVE; i++) begin
            if (issue_vld && ord_i[i*WID_W +: WID_W] == issue_wid) begin
                hit = 1'b1;
                k   = i;
            end
        end
        if (hit) begin
            for (int i = 0; i < MAX_ACTIVE; i++) begin
                idx = wts_pkg::wrap_slot(k + 1 + i, MAX_ACTIVE);
                rot_o[i*WID_W +: WID_W] = ord_i[idx*WID_W +: WID_W];
            end
        end
    end
endmodule

// File: rtl/wts_merge.sv
module wts_merge #(
    parameter int NUM_WARPS  = wts_pkg::DEF_WARPS,
    parameter int MAX_ACTIVE = wts_pkg::DEF_ACTIVE,
    parameter int WID_W      = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS*WID_W-1:0] rot_i,
    input  logic [NUM_WARPS-1:0]       stall_i,
    output logic [NUM_WARPS*WID_W-1:0] nxt_o
);
    localparam int NUM_PEND = NUM_WARPS - MAX_ACTIVE;

    // Survivors, then the old pending queue, then the demoted warps.
    // The first MAX_ACTIVE entries of the result form the new active set.
    always_comb begin
        logic [WID_W-1:0] w;
        int kc;
        int dc;
        nxt_o = rot_i;
        kc    = 0;
        for (int i = 0; i < MAX_ACTIVE; i++) begin
            w = rot_i[i*WID_W +: WID_W];
            if (!stall_i[w]) begin
                nxt_o[kc*WID_W +: WID_W] = w;
                kc++;
            end
        end
        for (int j = 0; j < NUM_PEND; j++)
            nxt_o[(kc + j)*WID_W +: WID_W] = rot_i[(MAX_ACTIVE + j)*WID_W +: WID_W];
        dc = kc + NUM_PEND;
        for (int i = 0; i < MAX_ACTIVE; i++) begin
            w = rot_i[i*WID_W +: WID_W];
            if (stall_i[w]) begin
                nxt_o[dc*WID_W +: WID_W] = w;
                dc++;
            end
        end
    end
endmodule

// File: rtl/warp_twolevel_sched.sv
module warp_twolevel_sched #(
    parameter int NUM_WARPS  = wts_pkg::DEF_WARPS,
    parameter int MAX_ACTIVE = wts_pkg::DEF_ACTIVE,
    parameter int NUM_SRC    = wts_pkg::DEF_SRCS,
    parameter int REG_W      = wts_pkg::DEF_REG_W,
    localparam int WID_W     = $clog2(NUM_WARPS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_WARPS-1:0]               wait_flag,
    input  logic [NUM_WARPS*NUM_SRC*REG_W-1:0] src_reg,
    input  logic [NUM_WARPS*(2**REG_W)-1:0]    long_busy,
    input  logic                               issue_vld,
    input  logic [WID_W-1:0]                   issue_wid,
    output logic [MAX_ACTIVE*WID_W-1:0]        act_list
);
    // Full order: entries [0, MAX_ACTIVE) are active, the rest is the pending queue.
    logic [NUM_WARPS*WID_W-1:0] order_q;
    logic [NUM_WARPS*WID_W-1:0] rot_ord;
    logic [NUM_WARPS*WID_W-1:0] nxt_ord;
    logic [NUM_WARPS-1:0]       stall;

    wts_stall_detect #(.NUM_WARPS(NUM_WARPS), .NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_stall (
        .wait_flag(wait_flag),
        .src_reg  (src_reg),
        .long_busy(long_busy),
        .stall_o  (stall)
    );

    wts_rotate #(.NUM_WARPS(NUM_WARPS), .MAX_ACTIVE(MAX_ACTIVE), .WID_W(WID_W)) u_rot (
        .ord_i    (order_q),
        .issue_vld(issue_vld),
        .issue_wid(issue_wid),
        .rot_o    (rot_ord)
    );

    wts_merge #(.NUM_WARPS(NUM_WARPS), .MAX_ACTIVE(MAX_ACTIVE), .WID_W(WID_W)) u_merge (
        .rot_i  (rot_ord),
        .stall_i(stall),
        .nxt_o  (nxt_ord)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WARPS; i++) order_q[i*WID_W +: WID_W] <= WID_W'(i);
        end else begin
            order_q <= nxt_ord;
        end
    end

    assign act_list = order_q[MAX_ACTIVE*WID_W-1:0];
endmodule

// File: rtl/wts_checker.sv
module wts_checker #(
    parameter int NUM_WARPS  = wts_pkg::DEF_WARPS,
    parameter int MAX_ACTIVE = wts_pkg::DEF_ACTIVE,
    parameter int NUM_SRC    = wts_pkg::DEF_SRCS,
    parameter int REG_W      = wts_pkg::DEF_REG_W,
    localparam int WID_W     = $clog2(NUM_WARPS)
) (
    input logic                               clk,
    input logic                               rst,
    input logic [NUM_WARPS-1:0]               wait_flag,
    input logic [NUM_WARPS*NUM_SRC*REG_W-1:0] src_reg,
    input logic [NUM_WARPS*(2**REG_W)-1:0]    long_busy,
    input logic                               issue_vld,
    input logic [WID_W-1:0]                   issue_wid,
    input logic [MAX_ACTIVE*WID_W-1:0]        act_list
);
    logic [NUM_WARPS-1:0]        act_mask;
    logic [MAX_ACTIVE*WID_W-1:0] ident;
    logic                        quiet;

    always_comb begin
        act_mask = '0;
        for (int i = 0; i < MAX_ACTIVE; i++) begin
            act_mask[act_list[i*WID_W +: WID_W]] = 1'b1;
            ident[i*WID_W +: WID_W] = WID_W'(i);
        end
    end

    assign quiet = (wait_flag == '0) && (long_busy == '0) && (src_reg == src_reg);

    // R7
    active_distinct_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(act_mask) == MAX_ACTIVE);

    // R1
    reset_order_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> act_list == ident);

    // R10
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!issue_vld && quiet) |=> $stable(act_list));

    // R8
    issue_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && act_mask[issue_wid] && quiet)
        |=> act_list[(MAX_ACTIVE-1)*WID_W +: WID_W] == $past(issue_wid));

    if (NUM_WARPS >= 2*MAX_ACTIVE) begin : g_demote
        for (genvar i = 0; i < MAX_ACTIVE; i++) begin : g_slot
            // R2
            flagged_leaves_chk: assert property (@(posedge clk) disable iff (rst)
                wait_flag[act_list[i*WID_W +: WID_W]]
                |=> !act_mask[$past(act_list[i*WID_W +: WID_W])]);
        end
    end
endmodule

bind warp_twolevel_sched wts_checker #(
    .NUM_WARPS(NUM_WARPS), .MAX_ACTIVE(MAX_ACTIVE), .NUM_SRC(NUM_SRC), .REG_W(REG_W)
) u_chk (
    .clk(clk), .rst(rst), .wait_flag(wait_flag), .src_reg(src_reg),
    .long_busy(long_busy), .issue_vld(issue_vld), .issue_wid(issue_wid),
    .act_list(act_list)
);

// File: tb/warp_twolevel_sched_bench.sv
module warp_twolevel_sched_bench;
    localparam int NW = 8;
    localparam int MA = 4;
    localparam int NS = 4;
    localparam int RW = 4;
    localparam int W  = 3;
    localparam int NR = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                rst;
    logic [NW-1:0]       wf;
    logic [NW*NS*RW-1:0] srcs;
    logic [NW*NR-1:0]    busy;
    logic                iv;
    logic [W-1:0]        iw;
    logic [MA*W-1:0]     act;

    logic [NW-1:0]       nwf;
    logic [NW*NS*RW-1:0] nsrcs;
    logic [NW*NR-1:0]    nbusy;

    warp_twolevel_sched #(.NUM_WARPS(NW), .MAX_ACTIVE(MA), .NUM_SRC(NS), .REG_W(RW)) u_warp_twolevel_sched (
        .clk(clk), .rst(rst), .wait_flag(wf), .src_reg(srcs), .long_busy(busy),
        .issue_vld(iv), .issue_wid(iw), .act_list(act)
    );

    typedef struct {
        logic [MA*W-1:0] exp;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int   model[NW];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    function automatic logic [MA*W-1:0] pack_act();
        logic [MA*W-1:0] r;
        for (int i = 0; i < MA; i++) r[i*W +: W] = W'(model[i]);
        return r;
    endfunction

    function automatic bit stalled(input int w);
        int r;
        if (wf[w]) return 1'b1;
        for (int s = 0; s < NS; s++) begin
            r = int'(srcs[(w*NS + s)*RW +: RW]);
            if (r != 0 && busy[w*NR + r]) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Reference order update from the requirements: rotate, then split, then refill.
    task automatic advance_model();
        int rot[NW];
        int nxt[NW];
        int k;
        int p;
        k = -1;
        p = 0;
        rot = model;
        if (iv) for (int i = 0; i < MA; i++) if (model[i] == int'(iw)) k = i;
        if (k >= 0) for (int i = 0; i < MA; i++) rot[i] = model[(k + 1 + i) % MA];
        for (int i = 0; i < MA; i++) if (!stalled(rot[i])) begin nxt[p] = rot[i]; p++; end
        for (int j = MA; j < NW; j++) begin nxt[p] = rot[j]; p++; end
        for (int i = 0; i < MA; i++) if (stalled(rot[i])) begin nxt[p] = rot[i]; p++; end
        model = nxt;
    endtask

    // Driver: applies the next inputs at a falling edge and queues the expected list.
    task automatic step(input bit v, input int wid, input string tag);
        exp_t e;
        @(negedge clk);
        wf = nwf; srcs = nsrcs; busy = nbusy;
        iv = v; iw = W'(wid);
        advance_model();
        e.exp = pack_act();
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic clear_next();
        nwf = '0; nsrcs = '0; nbusy = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: compares the list a little after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (!rst && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if (act !== e.exp) begin
                n_fail++;
                $display("FAIL %s act_list actual=%h expected=%h", e.tag, act, e.exp);
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; iv = 1'b0; iw = '0; wf = '0; srcs = '0; busy = '0;
        clear_next();
        for (int i = 0; i < NW; i++) model[i] = i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset order visible while reset is still high
        n_chk++;
        if (act !== pack_act()) begin
            n_fail++;
            $display("FAIL R1 act_list actual=%h expected=%h", act, pack_act());
        end
        rst = 1'b0;
        step(0, 0, "R1");

        // R10: no issue and no stall keeps the list
        repeat (3) step(0, 0, "R10");

        // R8: rotation on issue from first, last and middle slots
        step(1, model[0], "R8");
        step(1, model[MA-1], "R8");
        step(1, model[1], "R8");

        // R2 then R6: flagged head warp leaves, pending head refills
        nwf[model[0]] = 1'b1;
        step(0, 0, "R2");
        clear_next();
        step(0, 0, "R6");

        // R3: busy long-latency source register
        nsrcs[(model[1]*NS + 2)*RW +: RW] = RW'(5);
        nbusy[model[1]*NR + 5] = 1'b1;
        step(0, 0, "R3");
        clear_next();

        // R4: register zero is never a dependency
        nbusy[model[0]*NR + 0] = 1'b1;
        nbusy[model[2]*NR + 0] = 1'b1;
        step(0, 0, "R4");
        clear_next();

        // R5: two demotions in one cycle keep their order at the tail
        nwf[model[0]] = 1'b1;
        nwf[model[2]] = 1'b1;
        step(0, 0, "R5");
        clear_next();
        step(0, 0, "R6");
        step(0, 0, "R5");

        // R9: issuing warp stalled in the same cycle
        nwf[model[1]] = 1'b1;
        nwf[model[3]] = 1'b1;
        step(1, model[1], "R9");
        clear_next();
        step(1, model[2], "R9");

        // R7: mixed traffic
        for (int n = 0; n < 400; n++) begin
            clear_next();
            if ($urandom % 3 == 0) nwf[$urandom % NW] = 1'b1;
            for (int b = 0; b < NW*NS*RW; b += 32) nsrcs[b +: 32] = $urandom;
            repeat (3) nbusy[$urandom % (NW*NR)] = 1'b1;
            if ($urandom % 4 != 0) step(1, model[$urandom % MA], "R7");
            else                   step(0, 0, "R7");
        end

        clear_next();
        step(0, 0, "R10");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule